// File: doc/BRIEF.md
# Dual-Input Gate Command Qualifier with Standby Sequencer

This block sits between two control inputs of a gate driver and the output stage. It takes one non-inverting and one inverting logic input, brings each into the clock domain through a two-flop synchroniser, and rejects short glitches with a per-input run-length filter. The filtered pair is decoded into a single on/off gate command. The command is on only for the one combination that cannot cause cross-conduction.

The same two inputs also carry a low-power protocol, so no extra pin is needed. If both inputs stay high long enough, the block enters standby and holds the output in its safe state. To leave standby, the inputs must first rest in a non-standby combination. After that they must give one both-high pulse whose length falls inside a window. When that pulse is released, a fixed resume delay runs before the gate command may follow the inputs again. Every duration is a parameter counted in clock cycles.

The block has no streaming data path. All pins are plain level signals, and no valid/ready handshake or back-pressure applies.

Top module: `gdq_top`

## Requirements
- R1: Outside standby and resume, `gate_on_o` is 1 only when the filtered non-inverting input is 1 and the filtered inverting input is 0. Every other combination, including both high, gives 0.
- R2: A level on either input that lasts fewer than `DEGLITCH_CYC` cycles has no effect. A level held at least that long reaches the decoder `DEGLITCH_CYC`+2 clock edges after it is first sampled.
- R3: Both filtered inputs high for `ENTER_CYC` consecutive cycles enters standby. A shorter both-high run only gives gate off, and `standby_o` stays 0.
- R4: In standby, `gate_on_o` is 0 and `standby_o` is 1. Input changes other than the exit sequence leave both unchanged.
- R5: Exit is armed by a non-both-high combination held `ARM_CYC` cycles. It is followed by a both-high pulse of length L, where `WAKE_MIN_CYC` < L < `ENTER_CYC`. Releasing that pulse clears `standby_o` and starts the resume delay.
- R6: A wake pulse of length `WAKE_MIN_CYC` or less, or one that reaches `ENTER_CYC`, returns the sequencer to standby with `standby_o` still 1.
- R7: During the resume delay, `gate_on_o` stays 0 for `RESUME_CYC` cycles. After that, the gate command follows R1.
- R8: `force_safe_o` is 1 whenever the block is in standby, armed, in a wake pulse, or in the resume delay, and is 0 otherwise.
- R9: After reset, the block is active with all three outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| in_pos_i | input | 1 | Non-inverting control input |
| in_neg_i | input | 1 | Inverting control input |
| gate_on_o | output | 1 | Gate command, 1 = drive on |
| standby_o | output | 1 | Standby indication |
| force_safe_o | output | 1 | Request to hold the output stage safe |

## Verification
The decoder is driven through all four input combinations. This separates the single on-code from the three off-codes, the both-high code among them. Pulses one cycle below and at the filter length show whether the filter rejects or accepts at exactly the boundary. Both-high runs shorter and longer than the entry time show whether the interlock-off state and standby are kept apart. Wake pulses that are too short, too long and in the window show whether the exit check and the resume delay are timed correctly. A behavioural model is compared on every clock throughout.

// File: rtl/gdq_pkg.sv
package gdq_pkg;
  typedef enum logic [2:0] {
    SQ_ACTIVE  = 3'd0,
    SQ_STANDBY = 3'd1,
    SQ_ARMED   = 3'd2,
    SQ_PULSE   = 3'd3,
    SQ_DELAY   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/gdq_sync2.sv
module gdq_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gdq_deglitch.sv
module gdq_deglitch #(
  parameter int RUN_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (RUN_CYC < 2) ? 1 : $clog2(RUN_CYC);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_CYC - 1);

  logic [CW-1:0] run_q;

  // A differing level must persist RUN_CYC cycles before it is taken.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      q_o   <= 1'b0;
      run_q <= '0;
    end else if (d_i == q_o) begin
      run_q <= '0;
    end else if (run_q == RUN_LAST) begin
      q_o   <= d_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + CW'(1);
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_i == q_o) |=> $stable(q_o)); // R2
endmodule

// File: rtl/gdq_standby_seq.sv
module gdq_standby_seq
  import gdq_pkg::*;
#(
  parameter int ENTER_CYC    = 70000,
  parameter int ARM_CYC      = 70,
  parameter int WAKE_MIN_CYC = 5000,
  parameter int RESUME_CYC   = 35000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic gate_on_o,
  output logic standby_o,
  output logic force_safe_o
);
  localparam int MAX_AB = (ENTER_CYC > ARM_CYC) ? ENTER_CYC : ARM_CYC;
  localparam int MAX_CD = (RESUME_CYC > WAKE_MIN_CYC + 1) ? RESUME_CYC : WAKE_MIN_CYC + 1;
  localparam int MAXV   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXV + 1);
  localparam logic [CW-1:0] ENTER_LAST  = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] ARM_LAST    = CW'(ARM_CYC - 1);
  localparam logic [CW-1:0] RESUME_LAST = CW'(RESUME_CYC - 1);
  localparam logic [CW-1:0] WAKE_MIN    = CW'(WAKE_MIN_CYC);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          both_hi;

  assign both_hi = pos_i & neg_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SQ_ACTIVE: begin
        if (!both_hi)                cnt_d = '0;
        else if (cnt_q == ENTER_LAST) begin st_d = SQ_STANDBY; cnt_d = '0; end
        else                         cnt_d = cnt_q + CW'(1);
      end
      SQ_STANDBY: begin
        if (both_hi)                 cnt_d = '0;
        else if (cnt_q == ARM_LAST)  begin st_d = SQ_ARMED; cnt_d = '0; end
        else                         cnt_d = cnt_q + CW'(1);
      end
      SQ_ARMED: begin
        if (both_hi) begin st_d = SQ_PULSE; cnt_d = CW'(1); end
      end
      SQ_PULSE: begin
        if (both_hi) begin
          if (cnt_q == ENTER_LAST)   begin st_d = SQ_STANDBY; cnt_d = '0; end
          else                       cnt_d = cnt_q + CW'(1);
        end else begin
          st_d  = (cnt_q > WAKE_MIN) ? SQ_DELAY : SQ_STANDBY;
          cnt_d = '0;
        end
      end
      SQ_DELAY: begin
        if (cnt_q == RESUME_LAST)    begin st_d = SQ_ACTIVE; cnt_d = '0; end
        else                         cnt_d = cnt_q + CW'(1);
      end
      default: begin st_d = SQ_ACTIVE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q  <= SQ_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign gate_on_o    = (st_q == SQ_ACTIVE) & pos_i & ~neg_i;
  assign standby_o    = (st_q == SQ_STANDBY) | (st_q == SQ_ARMED) | (st_q == SQ_PULSE);
  assign force_safe_o = (st_q != SQ_ACTIVE);

  AST_ENTER_ON_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_STANDBY && $past(st_q) == SQ_ACTIVE) |-> $past(both_hi)); // R3
  AST_STBY_NO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !gate_on_o); // R4
  AST_WAKE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_DELAY && $past(st_q) == SQ_PULSE) |-> ($past(cnt_q) > WAKE_MIN && !$past(both_hi))); // R5
  AST_RESUME_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_ACTIVE && $past(st_q) != SQ_ACTIVE) |-> ($past(st_q) == SQ_DELAY)); // R7
endmodule

// File: rtl/gdq_top.sv
module gdq_top #(
  parameter int DEGLITCH_CYC = 5,
  parameter int ARM_CYC      = 70,
  parameter int WAKE_MIN_CYC = 5000,
  parameter int ENTER_CYC    = 70000,
  parameter int RESUME_CYC   = 35000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_pos_i,
  input  logic in_neg_i,
  output logic gate_on_o,
  output logic standby_o,
  output logic force_safe_o
);
  localparam int NIN = 2;

  logic [NIN-1:0] raw_in, sync_in, filt_in;

  assign raw_in = {in_neg_i, in_pos_i};

  gdq_sync2 #(.W(NIN)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(sync_in)
  );

  for (genvar g = 0; g < NIN; g++) begin : g_filt
    gdq_deglitch #(.RUN_CYC(DEGLITCH_CYC)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_in[g]), .q_o(filt_in[g])
    );
  end

  gdq_standby_seq #(
    .ENTER_CYC(ENTER_CYC), .ARM_CYC(ARM_CYC),
    .WAKE_MIN_CYC(WAKE_MIN_CYC), .RESUME_CYC(RESUME_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pos_i(filt_in[0]), .neg_i(filt_in[1]),
    .gate_on_o(gate_on_o), .standby_o(standby_o), .force_safe_o(force_safe_o)
  );

  AST_STBY_IS_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> force_safe_o); // R8
endmodule

// File: tb/tb_gdq_top.sv
module tb_gdq_top;
  localparam int DG = 3, ARM = 6, WMIN = 10, ENTER = 40, RESUME = 25;

  logic clk = 1'b0, rst_n = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
  logic gate_on, standby, force_safe;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gdq_top #(.DEGLITCH_CYC(DG), .ARM_CYC(ARM), .WAKE_MIN_CYC(WMIN),
            .ENTER_CYC(ENTER), .RESUME_CYC(RESUME)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_pos_i(in_pos), .in_neg_i(in_neg),
    .gate_on_o(gate_on), .standby_o(standby), .force_safe_o(force_safe));

  // Behavioural reference: 0 active, 1 standby, 2 armed, 3 pulse, 4 resume
  bit m_s1p, m_s2p, m_s1n, m_s2n, m_fp, m_fn, m_both;
  int m_cp, m_cn, m_st, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1p = 0; m_s2p = 0; m_s1n = 0; m_s2n = 0; m_fp = 0; m_fn = 0;
      m_cp = 0; m_cn = 0; m_st = 0; m_cnt = 0;
    end else begin
      m_both = m_fp && m_fn;
      if (m_st == 0) begin
        if (m_both) begin m_cnt++; if (m_cnt >= ENTER) begin m_st = 1; m_cnt = 0; end end
        else m_cnt = 0;
      end else if (m_st == 1) begin
        if (!m_both) begin m_cnt++; if (m_cnt >= ARM) begin m_st = 2; m_cnt = 0; end end
        else m_cnt = 0;
      end else if (m_st == 2) begin
        if (m_both) begin m_st = 3; m_cnt = 1; end
      end else if (m_st == 3) begin
        if (m_both) begin m_cnt++; if (m_cnt >= ENTER) begin m_st = 1; m_cnt = 0; end end
        else begin m_st = (m_cnt > WMIN) ? 4 : 1; m_cnt = 0; end
      end else begin
        m_cnt++; if (m_cnt >= RESUME) begin m_st = 0; m_cnt = 0; end
      end
      if (m_s2p == m_fp) m_cp = 0;
      else begin m_cp++; if (m_cp >= DG) begin m_fp = m_s2p; m_cp = 0; end end
      if (m_s2n == m_fn) m_cn = 0;
      else begin m_cn++; if (m_cn >= DG) begin m_fn = m_s2n; m_cn = 0; end end
      m_s2p = m_s1p; m_s1p = in_pos;
      m_s2n = m_s1n; m_s1n = in_neg;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 gate vs model", gate_on, (m_st == 0) && m_fp && !m_fn);
      chk("R4 standby vs model", standby, (m_st >= 1) && (m_st <= 3));
      chk("R8 force_safe vs model", force_safe, m_st != 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic p, logic n, int hold);
    in_pos = p; in_neg = n; cyc(hold);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    chk("R9 gate after reset", gate_on, 1'b0);
    chk("R9 standby after reset", standby, 1'b0);
    chk("R9 force_safe after reset", force_safe, 1'b0);

    // R1 truth table and R2 latency (DG+2 edges)
    in_pos = 1'b1; in_neg = 1'b0;
    cyc(DG + 1);
    chk("R2 not yet through filter", gate_on, 1'b0);
    cyc(1);
    chk("R2 accepted after DG+2 edges", gate_on, 1'b1);
    cyc(3);
    chk("R1 pos=1 neg=0 on", gate_on, 1'b1);
    drive(1'b0, 1'b1, 8); chk("R1 pos=0 neg=1 off", gate_on, 1'b0);
    drive(1'b0, 1'b0, 8); chk("R1 pos=0 neg=0 off", gate_on, 1'b0);
    drive(1'b1, 1'b0, 8);
    // R3 short both-high is interlock off, not standby
    drive(1'b1, 1'b1, 20);
    chk("R1 both high off", gate_on, 1'b0);
    chk("R3 short both-high no standby", standby, 1'b0);
    drive(1'b1, 1'b0, 10);
    chk("R3 still active after short run", gate_on, 1'b1);

    // R2 glitch below filter length
    in_pos = 1'b0; cyc(DG - 1); in_pos = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(1); chk("R2 glitch rejected", gate_on, 1'b1);
    end

    // R3 enter standby
    drive(1'b1, 1'b1, ENTER + 10);
    chk("R3 standby entered", standby, 1'b1);
    chk("R4 gate off in standby", gate_on, 1'b0);
    // R4 short non-standby blip does not arm or wake
    drive(1'b1, 1'b0, 4);
    drive(1'b1, 1'b1, 12);
    drive(1'b1, 1'b0, 8);
    chk("R4 input change keeps standby", standby, 1'b1);
    chk("R4 input change keeps gate off", gate_on, 1'b0);

    // R6 too-short wake pulse
    drive(1'b0, 1'b0, 15);
    drive(1'b1, 1'b1, WMIN - 5);
    drive(1'b1, 1'b0, 30);
    chk("R6 short pulse stays standby", standby, 1'b1);
    chk("R6 short pulse gate off", gate_on, 1'b0);

    // R6 too-long wake pulse
    drive(1'b1, 1'b1, ENTER + 5);
    drive(1'b1, 1'b0, 30);
    chk("R6 long pulse stays standby", standby, 1'b1);

    // R5 valid wake, R7 resume delay
    drive(1'b1, 1'b1, 20);
    drive(1'b1, 1'b0, 12);
    chk("R5 standby cleared after valid pulse", standby, 1'b0);
    chk("R7 gate held off during resume", gate_on, 1'b0);
    chk("R8 force_safe during resume", force_safe, 1'b1);
    cyc(RESUME + 5);
    chk("R7 gate follows inputs after resume", gate_on, 1'b1);
    chk("R8 force_safe released", force_safe, 1'b0);
    drive(1'b0, 1'b1, 10);
    chk("R7 R1 table after resume", gate_on, 1'b0);
    cyc(4);
    finish_run();
  end
endmodule